// File: doc/BRIEF.md
# Variable-Width Carry-Select Adder

This block adds two 64-bit operands and a carry-in, giving a 64-bit sum and a carry-out. Inside, the operand width is cut into ten segments of unequal size. The widths, from the least significant end, are 5, 5, 5, 6, 6, 7, 7, 8, 8 and 7 bits. The bottom segment is a single ripple-carry adder that takes the external carry-in.

Every higher segment holds two ripple-carry adders working side by side. One assumes an incoming carry of 0 and the other assumes 1. A 2:1 selector, steered by the real carry from the segment below, passes on the matching sum bits and segment carry. Once the operands are stable, no carry ripples inside a segment after its select arrives. The sizes grow toward the middle of the word. This balances the ripple time of each segment against the selector delay that builds up along the chain of segments.

The segment widths form a parameter array. A check at elaboration time rejects any set of widths that does not add up to the total width. The sum and carry-out leave the block through registers with a synchronous active-high reset, so each result appears one clock after its operands.

Top module: `csa_adder64`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` and `carry_out_q` become 0 on that edge.
- R2: After a rising edge with `rst` low, `sum_q` equals the low 64 bits of `op_a + op_b + carry_in` as sampled on that edge.
- R3: After a rising edge with `rst` low, `carry_out_q` equals bit 64 of the 65-bit value `op_a + op_b + carry_in` as sampled on that edge.
- R4: The segment widths, least significant first, are 5,5,5,6,6,7,7,8,8,7. The lowest bits of the segments are therefore 0,5,10,15,21,27,34,41,49 and 57. An all-ones operand plus 1 carries through every segment boundary and gives sum 0 with `carry_out_q` = 1.
- R5: An operand that is all ones except for one zero at bit k, plus 1, gives a sum whose bits below k are 0 and whose bits k and above are 1, with `carry_out_q` = 0. This holds for k at every segment's lowest bit and at bit 63.
- R6: An all-ones operand plus the single bit 2^k gives sum 2^k - 1 and `carry_out_q` = 1, for every k from 0 to 63.
- R7: Swapping `op_a` and `op_b` leaves `sum_q` and `carry_out_q` unchanged.
- R8: With `carry_in` = 1, an all-ones operand plus zero gives sum 0 and `carry_out_q` = 1. The pattern 3·2^k added to itself gives 6·2^k, for k from 0 to 62.
- R9: If all inputs keep their values over two consecutive edges with `rst` low, the outputs do not change on the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | 64 | Registered sum |
| carry_out_q | output | 1 | Registered carry out of bit 63 |

## Verification
The datapath is combinational up to one output register, so every sum and carry-out is due exactly one rising edge after its operands are applied. The bench changes inputs on falling edges. A behavioural model pushes the expected 65-bit value into a queue at each rising edge, and the bench pops it at the next falling edge to compare against the outputs. Directed vectors use the same one-edge timing: each vector's result is checked at the falling edge after the rising edge that captured it. Hold tests keep the inputs fixed for several edges to confirm the outputs stay put.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int CSA_W    = 64;
  localparam int CSA_NSEG = 10;
  typedef int seg_widths_t [CSA_NSEG];
  localparam seg_widths_t CSA_SEG_W = '{5, 5, 5, 6, 6, 7, 7, 8, 8, 7};
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end
  assign co = c[W];
endmodule

// File: rtl/csa_sel_mux.sv
module csa_sel_mux #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] s_zero,
  input  logic         c_zero,
  input  logic [W-1:0] s_one,
  input  logic         c_one,
  output logic [W-1:0] s,
  output logic         co
);
  always_comb begin
    if (sel) begin
      s  = s_one;
      co = c_one;
    end else begin
      s  = s_zero;
      co = c_zero;
    end
  end
endmodule

// File: rtl/csa_segment.sv
module csa_segment #(
  parameter int W      = 5,
  parameter bit DIRECT = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_ci,
  output logic [W-1:0] s,
  output logic         co
);
  if (DIRECT) begin : g_plain
    csa_ripple #(.W(W)) u_rc (
      .a(a), .b(b), .ci(sel_ci), .s(s), .co(co)
    );
  end else begin : g_dual
    logic [W-1:0] s0, s1;
    logic         c0, c1;
    csa_ripple #(.W(W)) u_rc0 (
      .a(a), .b(b), .ci(1'b0), .s(s0), .co(c0)
    );
    csa_ripple #(.W(W)) u_rc1 (
      .a(a), .b(b), .ci(1'b1), .s(s1), .co(c1)
    );
    csa_sel_mux #(.W(W)) u_mux (
      .sel(sel_ci), .s_zero(s0), .c_zero(c0), .s_one(s1), .c_one(c1),
      .s(s), .co(co)
    );
  end
endmodule

// File: rtl/csa_adder64.sv
module csa_adder64 #(
  parameter int WIDTH       = csa_pkg::CSA_W,
  parameter int NSEG        = csa_pkg::CSA_NSEG,
  parameter int SEG_W [NSEG] = csa_pkg::CSA_SEG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_out_q
);
  function automatic int seg_base(input int idx);
    int acc;
    acc = 0;
    for (int j = 0; j < idx; j++) acc += SEG_W[j];
    return acc;
  endfunction

  localparam int TOTAL = seg_base(NSEG);

  if (TOTAL != WIDTH) begin : g_width_bad
    $error("segment widths sum to %0d, expected %0d", TOTAL, WIDTH);
  end

  logic [NSEG:0]    seg_c;
  logic [WIDTH-1:0] sum_d;

  assign seg_c[0] = carry_in;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = seg_base(g);
    localparam int SW = SEG_W[g];
    csa_segment #(.W(SW), .DIRECT(g == 0)) u_seg (
      .a     (op_a[LO +: SW]),
      .b     (op_b[LO +: SW]),
      .sel_ci(seg_c[g]),
      .s     (sum_d[LO +: SW]),
      .co    (seg_c[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
    end else begin
      sum_q       <= sum_d;
      carry_out_q <= seg_c[NSEG];
    end
  end
endmodule

// File: rtl/csa_adder64_chk.sv
module csa_adder64_chk #(
  parameter int WIDTH = csa_pkg::CSA_W
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_q,
  input logic             carry_out_q
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !carry_out_q));

  // R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_q == $past(ref_total[WIDTH-1:0]));

  // R3
  carry_value_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> carry_out_q == $past(ref_total[WIDTH]));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(op_a) && $stable(op_b) && $stable(carry_in))
      |=> ($stable(sum_q) && $stable(carry_out_q)));
endmodule

bind csa_adder64 csa_adder64_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/csa_adder64_tb.sv
`timescale 1ns/1ps
module csa_adder64_tb;
  localparam int W = 64;
  localparam int LOWS [10] = '{0, 5, 10, 15, 21, 27, 34, 41, 49, 57};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         ci_i = 1'b0;
  logic [W-1:0] sum_q;
  logic         carry_out_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [W:0] model_q [$];

  always #2.5 clk = ~clk;

  csa_adder64 u_dut (
    .clk(clk), .rst(rst), .op_a(a_i), .op_b(b_i), .carry_in(ci_i),
    .sum_q(sum_q), .carry_out_q(carry_out_q)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural per-clock model
  always @(posedge clk) begin
    if (rst) model_q.push_back('0);
    else     model_q.push_back({1'b0, a_i} + {1'b0, b_i} + (W+1)'(ci_i));
  end

  always @(negedge clk) begin
    if (model_q.size() > 0) begin
      logic [W:0] e;
      e = model_q.pop_front();
      check("R2 sum", {1'b0, sum_q}, {1'b0, e[W-1:0]});
      check("R3 carry", {64'd0, carry_out_q}, {64'd0, e[W]});
    end
  end

  // called at a falling edge; result checked at the next falling edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                      input logic [W:0] exp, input string req);
    a_i = a; b_i = b; ci_i = c;
    @(negedge clk);
    check(req, {carry_out_q, sum_q}, exp);
  endtask

  task automatic both(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                      input logic [W:0] exp, input string req);
    step(a, b, c, exp, req);
    step(b, a, c, exp, {req, " R7 swapped"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {carry_out_q, sum_q}, '0);
    rst = 1'b0;

    // R4: all ones plus one ripples through every boundary
    both('1, 64'd1, 1'b0, {1'b1, 64'd0}, "R4");

    // R5: lone zero at each segment base and at the top bit
    for (int i = 0; i < 11; i++) begin
      int k;
      k = (i < 10) ? LOWS[i] : 63;
      both(~(64'd1 << k), 64'd1, 1'b0, {1'b0, ~((64'd1 << k) - 64'd1)}, "R5");
    end

    // R6: lone one at every position added to all ones
    for (int k = 0; k < 64; k++)
      both('1, 64'd1 << k, 1'b0, {1'b1, (64'd1 << k) - 64'd1}, "R6");

    // R8: carry-in alone carries across, and doubled 11 patterns
    both('1, '0, 1'b1, {1'b1, 64'd0}, "R8 cin");
    for (int k = 0; k < 63; k++)
      step(64'd3 << k, 64'd3 << k, 1'b0, 65'd6 << k, "R8 pair");

    // R9: held inputs keep outputs stable
    a_i = 64'h0123_4567_89ab_cdef; b_i = 64'hfedc_ba98_7654_3210; ci_i = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      logic [W:0] held;
      held = {carry_out_q, sum_q};
      @(negedge clk);
      check("R9 hold", {carry_out_q, sum_q}, held);
    end
    check("R9 value", {carry_out_q, sum_q}, {1'b1, 64'd0});

    // random operands, both orders
    for (int r = 0; r < 300; r++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = 1'($urandom);
      both(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + 65'(rc), "R2 R3 random");
    end

    // R1: reset mid-stream clears nonzero result
    a_i = '1; b_i = '1; ci_i = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {carry_out_q, sum_q}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 after reset", {carry_out_q, sum_q}, {1'b1, 64'hffff_ffff_ffff_ffff});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule